// File: doc/BRIEF.md
# Parallel Port FIFO Service Interrupt Controller

This block holds the sixteen-entry byte queue of an extended-capability parallel port and decides when the host must be told to service it. A host control write loads the whole control word in one strobe. The word holds a service-disable bit, a DMA enable, a transfer direction, an active-low error-interrupt enable, an acknowledge-interrupt enable, a queue enable and a 4-bit threshold code. The port side pushes and pops bytes. A DMA controller returns a terminal-count strobe when its transfer count runs out.

Service requests depend on the direction. When the port sends to the cable (direction 0), the host is asked for more bytes once enough entries are free. When the port receives from the cable (direction 1), the host is asked to drain the queue once enough entries are filled. A programmed-I/O transfer raises a level-sensitive interrupt flag. A DMA transfer holds a request line. The service-disable bit works with a clear-to-enable sense: writing 0 to it arms service. If the queue condition already holds at that moment, the interrupt is raised at once. A terminal count sets the service-disable bit again in hardware. Two further interrupt sources are a falling edge on the fault line and a rising edge on the acknowledge line. Both lines are synchronized before their edges are detected.

Top module: `pport_svc_ctrl`

## Requirements
- R1: After reset, irq and dma_req are 0, st_svc_dis is 1, st_level is 0 with st_empty 1, and the queue is disabled, so pushes are ignored until it is enabled.
- R2: With the queue enabled (cfg_fifo_en=1), it holds 16 bytes and returns them in push order, with pop_data showing the oldest entry. A push while full and a pop while empty are ignored. Disabling the queue empties it.
- R3: While st_svc_dis is 1, dma_req stays 0 and no queue-level (service) interrupt is raised.
- R4: In programmed-I/O mode (dma_en 0, svc_dis 0, direction 0), irq is set when the number of free entries becomes at least the code plus 1.
- R5: In programmed-I/O mode with direction 1, irq is set when the number of filled entries becomes at least 16 minus the code.
- R6: If the queue-level condition of R4/R5 already holds when svc_dis is written from 1 to 0, irq is set in the cycle after the register takes the new value.
- R7: With dma_en 1 and svc_dis 0, a dma_tc strobe sets irq and sets st_svc_dis to 1 on the next clock. A strobe while svc_dis is 1 has no effect.
- R8: dma_req is 1 exactly while dma_en is 1, svc_dis is 0, and the queue is not full (direction 0) or not empty (direction 1).
- R9: With the error enable cfg_err_en_n at 0, a high-to-low transition of fault_n sets irq. Writing cfg_err_en_n from 1 to 0 while fault_n is low also sets irq. With cfg_err_en_n at 1, a fault_n fall is ignored.
- R10: With cfg_ack_ie at 1, a low-to-high transition of ack_n sets irq. The falling edge does not. With cfg_ack_ie at 0, ack_n edges are ignored.
- R11: Once set, irq stays 1 until an irq_clr pulse clears it. A new interrupt event in the same cycle as the clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads all cfg_* fields into the control register |
| cfg_svc_dis | input | 1 | Service disable (1 blocks DMA and service interrupts) |
| cfg_dma_en | input | 1 | DMA mode enable |
| cfg_dir | input | 1 | 0: host to cable, 1: cable to host |
| cfg_err_en_n | input | 1 | Error interrupt enable, active low |
| cfg_ack_ie | input | 1 | Acknowledge interrupt enable |
| cfg_fifo_en | input | 1 | Queue enable; 0 flushes the queue |
| cfg_thr | input | 4 | Threshold code, one less than the threshold |
| fifo_push | input | 1 | Push strobe |
| push_data | input | 8 | Byte to push |
| fifo_pop | input | 1 | Pop strobe |
| pop_data | output | 8 | Oldest byte in the queue |
| dma_tc | input | 1 | DMA terminal-count strobe |
| fault_n | input | 1 | Asynchronous fault line, active low |
| ack_n | input | 1 | Asynchronous acknowledge line |
| irq_clr | input | 1 | Write-one-to-clear pulse for irq |
| irq | output | 1 | Sticky interrupt flag |
| dma_req | output | 1 | DMA service request |
| st_svc_dis | output | 1 | Current service-disable bit |
| st_level | output | 5 | Number of filled entries |
| st_full | output | 1 | Queue full |
| st_empty | output | 1 | Queue empty |

## Verification
The hardest case to reach is the immediate interrupt on re-enable. The queue level has to satisfy the threshold while service is disabled, so that no level crossing happens after service is armed. The stimulus fills or drains the queue with svc_dis held at 1, checks that irq stays low, and only then writes svc_dis to 0. A second hard case is the write-threshold test, which must watch free space cross from just below to just at the threshold. The bench first fills the queue past that point with service disabled, arms service, and then pops one byte at a time.

// File: rtl/pport_svc_pkg.sv
package pport_svc_pkg;
   // Control word held by the host-visible register
   typedef struct packed {
      logic svc_dis;
      logic dma_en;
      logic dir;
      logic err_en_n;
      logic ack_ie;
      logic fifo_en;
   } pport_ctrl_t;

   localparam pport_ctrl_t CTRL_RESET = '{svc_dis: 1'b1, dma_en: 1'b0, dir: 1'b0,
                                         err_en_n: 1'b1, ack_ie: 1'b0, fifo_en: 1'b0};
endpackage

// File: rtl/pport_edge_sync.sv
module pport_edge_sync #(
   parameter int   STAGES  = 2,
   parameter bit   RISE    = 1'b1,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic edge_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pport_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
         prev  <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], pin};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];

   generate
      if (RISE) begin : g_rise
         assign edge_o = level & ~prev;
      end else begin : g_fall
         assign edge_o = prev & ~level;
      end
   endgenerate
endmodule

// File: rtl/pport_byte_fifo.sv
module pport_byte_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign full    = (level == CW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = en & push & ~full;
   assign do_pop  = en & pop & ~empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/pport_svc_logic.sv
module pport_svc_logic
   import pport_svc_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int TW   = $clog2(DEPTH),
   localparam int CW   = TW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pport_ctrl_t   ctrl,
   input  logic [TW-1:0] thr,
   input  logic [CW-1:0] level,
   input  logic          dma_tc,
   input  logic          fault_lvl,
   input  logic          fault_fall,
   input  logic          ack_rise,
   input  logic          irq_clr,
   output logic          tc_hit,
   output logic          irq
);
   logic [CW-1:0] free_cnt, wr_thr, rd_thr;
   logic          lvl_cond, lvl_cond_q, err_en_n_q;
   logic          svc_evt, err_evt, ack_evt, any_evt;

   assign free_cnt = CW'(DEPTH) - level;
   assign wr_thr   = CW'(thr) + 1'b1;
   assign rd_thr   = CW'(DEPTH) - CW'(thr);

   assign lvl_cond = ~ctrl.svc_dis & ~ctrl.dma_en &
                     (ctrl.dir ? (level >= rd_thr) : (free_cnt >= wr_thr));
   assign svc_evt  = lvl_cond & ~lvl_cond_q;
   assign tc_hit   = dma_tc & ~ctrl.svc_dis & ctrl.dma_en;
   assign err_evt  = (~ctrl.err_en_n & fault_fall) |
                     (err_en_n_q & ~ctrl.err_en_n & ~fault_lvl);
   assign ack_evt  = ctrl.ack_ie & ack_rise;
   assign any_evt  = svc_evt | tc_hit | err_evt | ack_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_cond_q <= 1'b0;
         err_en_n_q <= 1'b1;
         irq        <= 1'b0;
      end else begin
         lvl_cond_q <= lvl_cond;
         err_en_n_q <= ctrl.err_en_n;
         if (any_evt)      irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/pport_svc_ctrl.sv
module pport_svc_ctrl
   import pport_svc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int TW         = $clog2(DEPTH),
   localparam int CW         = TW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_svc_dis,
   input  logic              cfg_dma_en,
   input  logic              cfg_dir,
   input  logic              cfg_err_en_n,
   input  logic              cfg_ack_ie,
   input  logic              cfg_fifo_en,
   input  logic [TW-1:0]     cfg_thr,
   input  logic              fifo_push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              fifo_pop,
   output logic [DATA_W-1:0] pop_data,
   input  logic              dma_tc,
   input  logic              fault_n,
   input  logic              ack_n,
   input  logic              irq_clr,
   output logic              irq,
   output logic              dma_req,
   output logic              st_svc_dis,
   output logic [CW-1:0]     st_level,
   output logic              st_full,
   output logic              st_empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pport_svc_ctrl: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pport_svc_ctrl: DATA_W must be positive");
      end
   endgenerate

   pport_ctrl_t ctrl_q;
   logic [TW-1:0] thr_q;
   logic tc_hit, fault_lvl, fault_fall, ack_lvl, ack_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         thr_q  <= '0;
      end else begin
         if (cfg_wr) begin
            ctrl_q <= '{svc_dis: cfg_svc_dis, dma_en: cfg_dma_en, dir: cfg_dir,
                        err_en_n: cfg_err_en_n, ack_ie: cfg_ack_ie, fifo_en: cfg_fifo_en};
            thr_q  <= cfg_thr;
         end
         if (tc_hit) ctrl_q.svc_dis <= 1'b1;
      end
   end

   pport_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.fifo_en),
      .push(fifo_push), .din(push_data), .pop(fifo_pop), .dout(pop_data),
      .level(st_level), .full(st_full), .empty(st_empty)
   );

   pport_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b0), .RST_VAL(1'b1)) u_fault (
      .clk(clk), .rst_n(rst_n), .pin(fault_n), .level(fault_lvl), .edge_o(fault_fall)
   );

   pport_edge_sync #(.STAGES(SYNC_STAGES), .RISE(1'b1), .RST_VAL(1'b1)) u_ack (
      .clk(clk), .rst_n(rst_n), .pin(ack_n), .level(ack_lvl), .edge_o(ack_rise)
   );

   pport_svc_logic #(.DEPTH(DEPTH)) u_svc (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .thr(thr_q), .level(st_level),
      .dma_tc(dma_tc), .fault_lvl(fault_lvl), .fault_fall(fault_fall),
      .ack_rise(ack_rise), .irq_clr(irq_clr), .tc_hit(tc_hit), .irq(irq)
   );

   assign dma_req    = ctrl_q.dma_en & ~ctrl_q.svc_dis &
                       (ctrl_q.dir ? ~st_empty : ~st_full);
   assign st_svc_dis = ctrl_q.svc_dis;

   logic unused_ack_lvl;
   assign unused_ack_lvl = ack_lvl;
endmodule

// File: rtl/pport_svc_ctrl_chk.sv
module pport_svc_ctrl_chk #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          dma_tc,
   input logic          irq_clr,
   input logic          fifo_push,
   input logic          fifo_pop,
   input logic          fifo_en,
   input logic          dma_en,
   input logic          irq,
   input logic          dma_req,
   input logic          st_svc_dis,
   input logic [CW-1:0] st_level,
   input logic          st_full,
   input logic          st_empty
);
   AST_SVC_BLOCKS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      st_svc_dis |-> !dma_req);                                            // R3
   AST_TC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_tc && !st_svc_dis && dma_en) |=> (st_svc_dis && irq));          // R7
   AST_DMAREQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> dma_en);                                                 // R8
   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);                                          // R11
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && st_full && fifo_push && !fifo_pop) |=> st_full);         // R2
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st_level <= CW'(DEPTH)) && !(st_full && st_empty));                 // R2
endmodule

bind pport_svc_ctrl pport_svc_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .dma_tc(dma_tc), .irq_clr(irq_clr),
   .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_en(ctrl_q.fifo_en),
   .dma_en(ctrl_q.dma_en), .irq(irq), .dma_req(dma_req), .st_svc_dis(st_svc_dis),
   .st_level(st_level), .st_full(st_full), .st_empty(st_empty)
);

// File: tb/tb_pport_svc_ctrl.sv
module tb_pport_svc_ctrl;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 0, cfg_svc_dis = 0, cfg_dma_en = 0, cfg_dir = 0;
   logic cfg_err_en_n = 1, cfg_ack_ie = 0, cfg_fifo_en = 0;
   logic [3:0] cfg_thr = 0;
   logic fifo_push = 0, fifo_pop = 0, dma_tc = 0, irq_clr = 0;
   logic fault_n = 1, ack_n = 1;
   logic [7:0] push_data = 0, pop_data;
   logic irq, dma_req, st_svc_dis, st_full, st_empty;
   logic [4:0] st_level;
   int checks = 0, failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pport_svc_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_svc_dis(cfg_svc_dis),
      .cfg_dma_en(cfg_dma_en), .cfg_dir(cfg_dir), .cfg_err_en_n(cfg_err_en_n),
      .cfg_ack_ie(cfg_ack_ie), .cfg_fifo_en(cfg_fifo_en), .cfg_thr(cfg_thr),
      .fifo_push(fifo_push), .push_data(push_data), .fifo_pop(fifo_pop),
      .pop_data(pop_data), .dma_tc(dma_tc), .fault_n(fault_n), .ack_n(ack_n),
      .irq_clr(irq_clr), .irq(irq), .dma_req(dma_req), .st_svc_dis(st_svc_dis),
      .st_level(st_level), .st_full(st_full), .st_empty(st_empty)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; fault_n = 1; ack_n = 1;
      cycles(3);
      rst_n = 1;
   endtask

   task automatic cfg(input bit sd, input bit de, input bit dr, input bit en_n,
                      input bit aie, input int thr, input bit fe);
      cfg_svc_dis = sd; cfg_dma_en = de; cfg_dir = dr; cfg_err_en_n = en_n;
      cfg_ack_ie = aie; cfg_thr = 4'(thr); cfg_fifo_en = fe; cfg_wr = 1;
      cycles(1);
      cfg_wr = 0;
   endtask

   task automatic push(input int v);
      fifo_push = 1; push_data = 8'(v);
      cycles(1);
      fifo_push = 0;
   endtask

   task automatic pop();
      fifo_pop = 1;
      cycles(1);
      fifo_pop = 0;
   endtask

   task automatic clear_irq();
      irq_clr = 1;
      cycles(1);
      irq_clr = 0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 irq", irq, 0);
      check("R1 dma_req", dma_req, 0);
      check("R1 svc_dis", st_svc_dis, 1);
      check("R1 empty", st_empty, 1);
      push(8'h11); cycles(1);
      check("R1 push ignored while disabled", st_level, 0);
   endtask

   task automatic t_fifo();
      do_reset();
      cfg(1, 0, 0, 1, 0, 0, 1);
      for (int i = 0; i < 17; i++) push(8'h40 + i);
      check("R2 full level", st_level, 16);
      check("R2 full flag", st_full, 1);
      for (int i = 0; i < 16; i++) begin
         check("R2 order", pop_data, 8'h40 + i);
         pop();
      end
      check("R2 empty", st_empty, 1);
      pop(); cycles(1);
      check("R2 pop on empty", st_level, 0);
      push(1); push(2); push(3);
      cfg(1, 0, 0, 1, 0, 0, 0); cycles(1);
      check("R2 flush on disable", st_level, 0);
      check("R2 irq stays 0", irq, 0);
   endtask

   task automatic t_block();
      do_reset();
      cfg(1, 1, 0, 1, 0, 0, 1); cycles(3);
      check("R3 dma_req blocked", dma_req, 0);
      check("R3 service irq blocked", irq, 0);
   endtask

   task automatic t_wthr();
      do_reset();
      cfg(1, 0, 0, 1, 0, 3, 1);
      for (int i = 0; i < 14; i++) push(i);
      cfg(0, 0, 0, 1, 0, 3, 1); cycles(2);
      check("R4 free 2 below thr 4", irq, 0);
      pop(); cycles(2);
      check("R4 free 3 below thr 4", irq, 0);
      pop(); cycles(2);
      check("R4 free 4 reaches thr", irq, 1);
   endtask

   task automatic t_rthr();
      do_reset();
      cfg(0, 0, 1, 1, 0, 12, 1); cycles(2);
      check("R5 empty no irq", irq, 0);
      push(1); push(2); push(3); cycles(2);
      check("R5 3 below thr 4", irq, 0);
      push(4); cycles(2);
      check("R5 4 reaches thr", irq, 1);
   endtask

   task automatic t_reenable();
      do_reset();
      cfg(1, 0, 1, 1, 0, 12, 1);
      for (int i = 0; i < 5; i++) push(i);
      cycles(2);
      check("R6 no irq while disabled", irq, 0);
      cfg(0, 0, 1, 1, 0, 12, 1); cycles(1);
      check("R6 immediate irq on re-enable", irq, 1);
   endtask

   task automatic t_dma_tc();
      do_reset();
      cfg(0, 1, 0, 1, 0, 0, 1);
      check("R8 dma_req with room", dma_req, 1);
      dma_tc = 1; cycles(1); dma_tc = 0;
      check("R7 tc sets svc_dis", st_svc_dis, 1);
      check("R7 tc sets irq", irq, 1);
      check("R7 dma_req drops", dma_req, 0);
      clear_irq();
      check("R11 clear", irq, 0);
      dma_tc = 1; cycles(1); dma_tc = 0; cycles(1);
      check("R7 tc ignored when disabled", irq, 0);
   endtask

   task automatic t_dma_req();
      do_reset();
      cfg(0, 1, 0, 1, 0, 0, 1);
      for (int i = 0; i < 16; i++) push(i);
      check("R8 full blocks write req", dma_req, 0);
      cfg(0, 1, 1, 1, 0, 0, 1);
      check("R8 read req with data", dma_req, 1);
      for (int i = 0; i < 16; i++) pop();
      check("R8 empty blocks read req", dma_req, 0);
      check("R8 no level irq in dma mode", irq, 0);
   endtask

   task automatic t_fault();
      do_reset();
      cfg(1, 0, 0, 0, 0, 0, 0); cycles(2);
      check("R9 no irq before fault", irq, 0);
      fault_n = 0; cycles(5);
      check("R9 fault fall", irq, 1);
      fault_n = 1; cycles(4);
      clear_irq();
      cfg(1, 0, 0, 1, 0, 0, 0);
      fault_n = 0; cycles(6);
      check("R9 fall ignored when masked", irq, 0);
      cfg(1, 0, 0, 0, 0, 0, 0); cycles(2);
      check("R9 enable while fault low", irq, 1);
      fault_n = 1;
   endtask

   task automatic t_ack();
      do_reset();
      cfg(1, 0, 0, 1, 1, 0, 0);
      ack_n = 0; cycles(5);
      check("R10 falling ack no irq", irq, 0);
      ack_n = 1; cycles(5);
      check("R10 rising ack irq", irq, 1);
      clear_irq();
      cfg(1, 0, 0, 1, 0, 0, 0);
      ack_n = 0; cycles(5); ack_n = 1; cycles(5);
      check("R10 ack ignored when off", irq, 0);
   endtask

   task automatic t_sticky();
      do_reset();
      cfg(1, 0, 0, 1, 1, 0, 0);
      ack_n = 0; cycles(4); ack_n = 1; cycles(5);
      check("R11 set", irq, 1);
      cycles(10);
      check("R11 held", irq, 1);
      clear_irq();
      check("R11 cleared", irq, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_fifo();
      t_block();
      t_wthr();
      t_rthr();
      t_reenable();
      t_dma_tc();
      t_dma_req();
      t_fault();
      t_ack();
      t_sticky();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule